// File: doc/BRIEF.md
# UART FIFO-Level Interrupt Controller

This block turns the fill levels and push/pop activity of a UART's receive and transmit FIFOs into interrupt status, and folds that status into a single interrupt line. It watches the receive side for overrun, for a fill level above a programmable threshold, and for data that has sat in the FIFO too long. On the transmit side it watches for an empty FIFO and for a fill level below a programmable threshold. A modem-line event summary arrives as an input and is treated as one more source. The FIFO storage and the serial shifters live elsewhere. This block only sees their levels, strobes and a bit-time tick.

Software reaches the block through a two-register write port: an interrupt register that carries the mask bits, and a control register that carries the two thresholds, the timeout length and two FIFO-reset command bits. The full interrupt word is always visible on a read-back bus. It holds the status bits, the mask bits, a receive-not-empty flag and the transmit fill count, so software can work out how many free transmit entries remain.

Top module: `sio_irq_ctrl`

## Requirements
- R1: While reset is asserted, the interrupt output, both FIFO-reset pulses and bits [13:0] of the interrupt word are all zero.
- R2: Status bit 1 (receive threshold) is set one cycle after the receive fill level is strictly greater than the receive threshold field, and is clear otherwise.
- R3: Status bit 3 (transmit empty) follows a transmit fill level of zero, and status bit 4 (transmit threshold) follows a transmit fill level strictly less than the transmit threshold field. Both take one cycle.
- R4: Status bit 0 (receive overrun) is set by a receive push while the receive level equals the FIFO depth (16). It stays set through any write to the interrupt register and clears only on the cycle after a receive FIFO reset pulse. A push below full does not set it.
- R5: Writing control register (address 1) with bit 24 set drives the receive FIFO reset output high for exactly the following cycle. Bit 25 does the same for the transmit FIFO reset output.
- R6: Status bit 2 (receive timeout) sets once the receive FIFO has stayed non-empty for the programmed number of character times, counted as bit ticks times CHAR_TICKS (10), with no push or pop. A push, a pop or an empty FIFO clears it, and holds the count at zero. A timeout length of zero disables it.
- R7: The interrupt output is the OR over bits [5:0] of status AND mask (mask in bits [13:8], written through address 0, bits [13:8]). It is registered, so it appears one cycle after the status and mask that cause it.
- R8: Status bit 5 follows the modem event input with one cycle of delay.
- R9: Interrupt word bit 6 shows the receive FIFO as not empty (one cycle delay), and bits [20:16] show the current transmit fill count.
- R10: The control register fields are the receive threshold in bits [4:0], the transmit threshold in bits [12:8] and the timeout length in character times in bits [19:16]. They reset to 8, 8 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | 5 | Receive FIFO fill count |
| tx_level | input | 5 | Transmit FIFO fill count |
| rx_push | input | 1 | A character was written into the receive FIFO |
| rx_pop | input | 1 | A character was read from the receive FIFO |
| bit_tick | input | 1 | One pulse per serial bit time |
| modem_evt | input | 1 | Modem-line change summary |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the interrupt register, 1 selects the control register |
| reg_wdata | input | 32 | Write data |
| irq_word | output | 32 | Read-back interrupt word |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO reset pulse |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO reset pulse |
| irq | output | 1 | Interrupt output |

## Verification
The threshold compares are driven exactly at their boundaries. A design that used "greater or equal" for the receive side, or "less or equal" for the transmit side, fires at level 8 with the default thresholds, or at 3 and 2 after reprogramming. Overrun is tested for stickiness across a write to the interrupt register and for clearing only after the reset pulse, so status that self-clears or clears on write shows up. A push at level 15 must not set it. The timeout is walked tick by tick to one short of a character time and then to exactly one, then cleared by a pop, then held off by an empty FIFO and by a zero length, which exposes off-by-one limits and a counter that is not cleared.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
   // interrupt source positions in the status and mask fields
   localparam int SRC_RX_OVR  = 0;
   localparam int SRC_RX_THR  = 1;
   localparam int SRC_RX_TMO  = 2;
   localparam int SRC_TX_EMP  = 3;
   localparam int SRC_TX_THR  = 4;
   localparam int SRC_MODEM   = 5;
   localparam int NUM_SRC     = 6;

   // read-back word layout
   localparam int WORD_MASK_LSB = 8;
   localparam int WORD_RXNE_BIT = 6;
   localparam int WORD_TXLV_LSB = 16;

   // control register layout
   localparam int CTL_RXTHR_LSB = 0;
   localparam int CTL_TXTHR_LSB = 8;
   localparam int CTL_TMO_LSB   = 16;
   localparam int CTL_RXRST_BIT = 24;
   localparam int CTL_TXRST_BIT = 25;

   typedef enum logic {
      REG_IRQ  = 1'b0,
      REG_CTRL = 1'b1
   } sio_reg_e;
endpackage

// File: rtl/sio_irq_cfg.sv
module sio_irq_cfg
   import sio_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int CNT_W      = 5,
   parameter int TMO_W      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [NUM_SRC-1:0] mask,
   output logic [CNT_W-1:0]   rx_thr,
   output logic [CNT_W-1:0]   tx_thr,
   output logic [TMO_W-1:0]   tmo_chars,
   output logic               rx_rst,
   output logic               tx_rst
);
   localparam logic [CNT_W-1:0] THR_RST = CNT_W'(FIFO_DEPTH / 2);

   logic wr_irq, wr_ctl;
   assign wr_irq = reg_wr && (sio_reg_e'(reg_addr) == REG_IRQ);
   assign wr_ctl = reg_wr && (sio_reg_e'(reg_addr) == REG_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask      <= '0;
         rx_thr    <= THR_RST;
         tx_thr    <= THR_RST;
         tmo_chars <= TMO_W'(1);
         rx_rst    <= 1'b0;
         tx_rst    <= 1'b0;
      end else begin
         rx_rst <= wr_ctl && reg_wdata[CTL_RXRST_BIT];
         tx_rst <= wr_ctl && reg_wdata[CTL_TXRST_BIT];
         if (wr_irq)
            mask <= reg_wdata[WORD_MASK_LSB +: NUM_SRC];
         if (wr_ctl) begin
            rx_thr    <= reg_wdata[CTL_RXTHR_LSB +: CNT_W];
            tx_thr    <= reg_wdata[CTL_TXTHR_LSB +: CNT_W];
            tmo_chars <= reg_wdata[CTL_TMO_LSB +: TMO_W];
         end
      end
   end

   // R5: a reset pulse only follows a control write carrying its command bit
   a_r5_rx_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst |-> $past(reg_wr && reg_addr && reg_wdata[CTL_RXRST_BIT]));
   a_r5_tx_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rst |-> $past(reg_wr && reg_addr && reg_wdata[CTL_TXRST_BIT]));
endmodule

// File: rtl/sio_rx_timeout.sv
module sio_rx_timeout #(
   parameter int CNT_W      = 5,
   parameter int TMO_W      = 4,
   parameter int CHAR_TICKS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_level,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic             rx_rst,
   input  logic             bit_tick,
   input  logic [TMO_W-1:0] tmo_chars,
   output logic             expired
);
   localparam int LIM_W = TMO_W + $clog2(CHAR_TICKS + 1);

   logic [LIM_W-1:0] limit, cnt;
   logic             clr;

   assign limit = LIM_W'(tmo_chars) * LIM_W'(CHAR_TICKS);
   assign clr   = (rx_level == '0) || rx_push || rx_pop || rx_rst;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt <= '0;
      else if (bit_tick && (cnt < limit))
         cnt <= cnt + LIM_W'(1);
   end

   assign expired = (limit != '0) && (cnt >= limit) && !clr;
endmodule

// File: rtl/sio_irq_status.sv
module sio_irq_status
   import sio_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int CNT_W      = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   rx_level,
   input  logic [CNT_W-1:0]   tx_level,
   input  logic               rx_push,
   input  logic               rx_rst,
   input  logic [CNT_W-1:0]   rx_thr,
   input  logic [CNT_W-1:0]   tx_thr,
   input  logic               tmo_expired,
   input  logic               modem_evt,
   output logic [NUM_SRC-1:0] status,
   output logic               rx_nempty
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);

   logic [NUM_SRC-1:0] level_src;
   logic               ovr_set;

   always_comb begin
      level_src             = '0;
      level_src[SRC_RX_THR] = rx_level > rx_thr;
      level_src[SRC_RX_TMO] = tmo_expired;
      level_src[SRC_TX_EMP] = tx_level == '0;
      level_src[SRC_TX_THR] = tx_level < tx_thr;
      level_src[SRC_MODEM]  = modem_evt;
   end

   assign ovr_set = rx_push && (rx_level == FULL);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == SRC_RX_OVR) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n || rx_rst)
               status[i] <= 1'b0;
            else if (ovr_set)
               status[i] <= 1'b1;
         end
      end else begin : g_level
         always_ff @(posedge clk) begin
            if (!rst_n)
               status[i] <= 1'b0;
            else
               status[i] <= level_src[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rx_nempty <= 1'b0;
      else
         rx_nempty <= rx_level != '0;
   end

   // R4: overrun holds until a receive FIFO reset pulse
   a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[SRC_RX_OVR] && !rx_rst) |=> status[SRC_RX_OVR]);
   a_r4_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[SRC_RX_OVR]) |-> $past(rx_push));
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
   import sio_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int TMO_W      = 4,
   parameter int CHAR_TICKS = 10,
   parameter bit IRQ_REG    = 1'b1,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_level,
   input  logic [CNT_W-1:0] tx_level,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic             bit_tick,
   input  logic             modem_evt,
   input  logic             reg_wr,
   input  logic             reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      irq_word,
   output logic             rx_fifo_rst,
   output logic             tx_fifo_rst,
   output logic             irq
);
   if (FIFO_DEPTH < 2 || CNT_W > 8) begin : g_bad_depth
      $error("sio_irq_ctrl: FIFO_DEPTH must be 2..255");
   end
   if (TMO_W < 1 || TMO_W > 8) begin : g_bad_tmo
      $error("sio_irq_ctrl: TMO_W must be 1..8");
   end
   if (CHAR_TICKS < 1) begin : g_bad_ticks
      $error("sio_irq_ctrl: CHAR_TICKS must be positive");
   end

   logic [NUM_SRC-1:0] mask, status;
   logic [CNT_W-1:0]   rx_thr, tx_thr;
   logic [TMO_W-1:0]   tmo_chars;
   logic               rx_rst, tx_rst, tmo_expired, rx_nempty, irq_next;

   sio_irq_cfg #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .CNT_W      (CNT_W),
      .TMO_W      (TMO_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .mask      (mask),
      .rx_thr    (rx_thr),
      .tx_thr    (tx_thr),
      .tmo_chars (tmo_chars),
      .rx_rst    (rx_rst),
      .tx_rst    (tx_rst)
   );

   sio_rx_timeout #(
      .CNT_W      (CNT_W),
      .TMO_W      (TMO_W),
      .CHAR_TICKS (CHAR_TICKS)
   ) u_tmo (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_level  (rx_level),
      .rx_push   (rx_push),
      .rx_pop    (rx_pop),
      .rx_rst    (rx_rst),
      .bit_tick  (bit_tick),
      .tmo_chars (tmo_chars),
      .expired   (tmo_expired)
   );

   sio_irq_status #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .CNT_W      (CNT_W)
   ) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_level    (rx_level),
      .tx_level    (tx_level),
      .rx_push     (rx_push),
      .rx_rst      (rx_rst),
      .rx_thr      (rx_thr),
      .tx_thr      (tx_thr),
      .tmo_expired (tmo_expired),
      .modem_evt   (modem_evt),
      .status      (status),
      .rx_nempty   (rx_nempty)
   );

   assign irq_next = |(status & mask);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq <= 1'b0;
         else
            irq <= irq_next;
      end

      // R7: the line reflects the masked status of the previous cycle
      a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(|(irq_word[NUM_SRC-1:0] & irq_word[WORD_MASK_LSB +: NUM_SRC])));
   end else begin : g_irq_comb
      assign irq = irq_next;
   end

   always_comb begin
      irq_word                                = '0;
      irq_word[NUM_SRC-1:0]                   = status;
      irq_word[WORD_RXNE_BIT]                 = rx_nempty;
      irq_word[WORD_MASK_LSB +: NUM_SRC]      = mask;
      irq_word[WORD_TXLV_LSB +: CNT_W]        = tx_level;
   end

   assign rx_fifo_rst = rx_rst;
   assign tx_fifo_rst = tx_rst;

   // R6: a timeout is only reported after a cycle with data in the FIFO
   a_r6_tmo_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      irq_word[SRC_RX_TMO] |-> $past(rx_level != '0));
endmodule

// File: tb/sio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module sio_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rx_level = '0, tx_level = '0;
   logic        rx_push = 1'b0, rx_pop = 1'b0, bit_tick = 1'b0, modem_evt = 1'b0;
   logic        reg_wr = 1'b0, reg_addr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] irq_word;
   logic        rx_fifo_rst, tx_fifo_rst, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [31:0] CTRL_DEF = 32'h0001_0808;

   // {rx_level, tx_level, modem_evt, expected word bits [6:0]}
   localparam logic [17:0] VEC [6] = '{
      {5'd0,  5'd0,  1'b0, 7'b0011000},
      {5'd8,  5'd8,  1'b0, 7'b1000000},
      {5'd9,  5'd7,  1'b1, 7'b1110010},
      {5'd16, 5'd16, 1'b0, 7'b1000010},
      {5'd1,  5'd0,  1'b1, 7'b1111000},
      {5'd0,  5'd15, 1'b0, 7'b0000000}
   };

   always #2.5 clk = ~clk;

   sio_irq_ctrl u_sio_irq_ctrl (
      .clk (clk), .rst_n (rst_n), .rx_level (rx_level), .tx_level (tx_level),
      .rx_push (rx_push), .rx_pop (rx_pop), .bit_tick (bit_tick),
      .modem_evt (modem_evt), .reg_wr (reg_wr), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .irq_word (irq_word), .rx_fifo_rst (rx_fifo_rst),
      .tx_fifo_rst (tx_fifo_rst), .irq (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); bit_tick = 1'b1;
         @(negedge clk); bit_tick = 1'b0;
      end
   endtask

   task automatic settle();
      @(negedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 word", {18'd0, irq_word[13:0]}, 32'd0);
      check("R1 irq and pulses", {irq, rx_fifo_rst, tx_fifo_rst}, 3'b000);
      rst_n = 1'b1;

      // R2 R3 R8 R9 R10: level-driven status with reset thresholds
      for (int v = 0; v < 6; v++) begin
         @(negedge clk);
         rx_level = VEC[v][17:13]; tx_level = VEC[v][12:8]; modem_evt = VEC[v][7];
         settle();
         check("R2 R3 R8 R9 vector", {25'd0, irq_word[6:0]}, {25'd0, VEC[v][6:0]});
      end

      // R9: transmit fill count readback
      @(negedge clk); tx_level = 5'd13; modem_evt = 1'b0; rx_level = 5'd0;
      settle();
      check("R9 tx level", {27'd0, irq_word[20:16]}, 32'd13);

      // R7: mask and registered interrupt
      @(negedge clk); tx_level = 5'd0;
      settle();
      wr(1'b0, 32'h0000_0800);
      check("R7 irq one cycle late", {31'd0, irq}, 32'd0);
      @(negedge clk);
      check("R7 irq asserted", {31'd0, irq}, 32'd1);
      wr(1'b0, 32'h0000_2000);
      @(negedge clk);
      check("R7 masked source only", {31'd0, irq}, 32'd0);

      // R4: overrun set, sticky, cleared only by reset
      @(negedge clk); rx_level = 5'd15; rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
      @(negedge clk);
      check("R4 no overrun below full", {31'd0, irq_word[0]}, 32'd0);
      @(negedge clk); rx_level = 5'd16; rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
      @(negedge clk);
      check("R4 overrun set", {31'd0, irq_word[0]}, 32'd1);
      wr(1'b0, 32'h0000_0000);
      @(negedge clk);
      check("R4 overrun survives write", {31'd0, irq_word[0]}, 32'd1);
      @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = CTRL_DEF | (32'd1 << 24);
      @(negedge clk); reg_wr = 1'b0;
      check("R5 rx reset pulse", {30'd0, rx_fifo_rst, tx_fifo_rst}, 32'b10);
      @(negedge clk);
      check("R5 rx pulse one cycle", {31'd0, rx_fifo_rst}, 32'd0);
      check("R4 overrun cleared", {31'd0, irq_word[0]}, 32'd0);
      @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = CTRL_DEF | (32'd1 << 25);
      @(negedge clk); reg_wr = 1'b0;
      check("R5 tx reset pulse", {30'd0, rx_fifo_rst, tx_fifo_rst}, 32'b01);
      @(negedge clk);
      check("R5 tx pulse one cycle", {31'd0, tx_fifo_rst}, 32'd0);

      // R6: timeout of one character time (10 ticks)
      @(negedge clk); rx_level = 5'd3;
      ticks(9);
      settle();
      check("R6 not yet expired", {31'd0, irq_word[2]}, 32'd0);
      ticks(1);
      settle();
      check("R6 expired", {31'd0, irq_word[2]}, 32'd1);
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
      @(negedge clk);
      check("R6 cleared by pop", {31'd0, irq_word[2]}, 32'd0);
      @(negedge clk); rx_level = 5'd0;
      ticks(15);
      settle();
      check("R6 held while empty", {31'd0, irq_word[2]}, 32'd0);

      // R10: reprogrammed thresholds, zero timeout disables
      wr(1'b1, 32'h0000_0203);
      @(negedge clk); rx_level = 5'd4; tx_level = 5'd1;
      settle();
      check("R10 new thresholds met", {30'd0, irq_word[4], irq_word[1]}, 32'b11);
      @(negedge clk); rx_level = 5'd3; tx_level = 5'd2;
      settle();
      check("R10 thresholds at boundary", {30'd0, irq_word[4], irq_word[1]}, 32'b00);
      @(negedge clk); rx_level = 5'd4;
      ticks(20);
      settle();
      check("R6 zero length disabled", {31'd0, irq_word[2]}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule